// File: doc/BRIEF.md
# Per-Bit Access-Mode Register Cell

This block is one software-visible control/status register whose bits each follow their own access rule. A bit is given one of nine rules at elaboration time through a packed mode vector, four bits per register bit. Software reaches the register over a simple bus that has an address, write and read enables, write data, per-byte write strobes and combinational read data. Hardware logic next to the register can force any bit to 1 or to 0 with event inputs. It sees the stored value of every bit on a parallel output and receives a one-cycle pulse from any bit configured as a write trigger.

The bit rules are: ordinary read/write storage; read-only (hardware-owned); write-only (reads give the reset value); clear when 1 is written; clear when 0 is written; clear after a read; set when 1 is written; a pulse on any write; and invert when 1 is written. Hardware events take priority over software. A hardware set beats a hardware clear, and both beat any software action in the same cycle, so no hardware event is lost.

Top module: `regcell_field`

## Requirements
- R1: On reset every stored bit takes its bit of RESET_VAL and no trigger pulse is active. A read of the register then returns RESET_VAL.
- R2: A bit with mode code 0 (read/write) stores write data when its byte lane is strobed (bus_bstrb bit k covers data bits 8k to 8k+7). Bits in lanes that are not strobed keep their value.
- R3: A bit with mode code 1 (read-only) is unchanged by software writes. It follows only hw_set and hw_clr.
- R4: A bit with mode code 2 (write-only) stores written data, which is visible on hw_val. A read returns its RESET_VAL bit whatever was written.
- R5: A bit with mode code 3 becomes 0 when software writes 1 to it. Writing 0 leaves it unchanged.
- R6: A bit with mode code 4 becomes 0 when software writes 0 to it. Writing 1 leaves it unchanged.
- R7: A bit with mode code 5 returns its value on a read and is 0 after that clock edge. Writes do not change it. A read with bus_rd_en low, or at a different address, does not clear it.
- R8: A bit with mode code 6 becomes 1 when software writes 1. Writing 0 has no effect.
- R9: A bit with mode code 7 raises trig_pulse for exactly the one cycle after any strobed write to it, whether the written value is 0 or 1. Its stored value is not changed by software.
- R10: A bit with mode code 8 inverts when software writes 1. Writing 0 has no effect.
- R11: hw_set takes priority over hw_clr, and both take priority over any software effect in the same cycle. A clear-after-read bit that is set by hardware during the read cycle stays 1.
- R12: Writes and reads act only when bus_addr equals REG_ADDR. bus_rdata is 0 whenever no read of REG_ADDR is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr_en | input | 1 | Write enable |
| bus_rd_en | input | 1 | Read enable |
| bus_wdata | input | DATA_W | Write data |
| bus_bstrb | input | DATA_W/8 | Byte-lane write strobes |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when idle |
| hw_set | input | DATA_W | Per-bit hardware set event |
| hw_clr | input | DATA_W | Per-bit hardware clear event |
| hw_val | output | DATA_W | Stored value of each bit |
| trig_pulse | output | DATA_W | One-cycle pulse of write-trigger bits |

## Verification
The bench builds a 16-bit register at address 6. Bits 0 to 8 carry mode codes 0 to 8 in order. Bit 10 is a second write-1-clear bit, bit 11 is a second clear-after-read bit, and the remaining bits are read/write. With RESET_VAL 16'h1014, the write-only, write-0-clear and upper-lane bits start at 1. This lets the bench see a reset value through a read and catch writes that leak into an unstrobed lane. Since every mode sits in one register, one bus cycle reaches all nine rules at once, and the hardware-versus-software races can be driven on the exact bit they concern.

// File: rtl/regcell_pkg.sv
package regcell_pkg;

   localparam int MODE_W = 4;

   localparam logic [MODE_W-1:0] ACC_RW   = 4'd0;
   localparam logic [MODE_W-1:0] ACC_RO   = 4'd1;
   localparam logic [MODE_W-1:0] ACC_WO   = 4'd2;
   localparam logic [MODE_W-1:0] ACC_W1C  = 4'd3;
   localparam logic [MODE_W-1:0] ACC_W0C  = 4'd4;
   localparam logic [MODE_W-1:0] ACC_RCLR = 4'd5;
   localparam logic [MODE_W-1:0] ACC_W1S  = 4'd6;
   localparam logic [MODE_W-1:0] ACC_TRIG = 4'd7;
   localparam logic [MODE_W-1:0] ACC_W1T  = 4'd8;
   localparam logic [MODE_W-1:0] ACC_LAST = ACC_W1T;

   // per-bit control bundle handed from decode to each cell
   typedef struct packed {
      logic wr;    // strobed write to this bit
      logic wd;    // written value
      logic rd;    // read of the register
      logic hset;  // hardware set
      logic hclr;  // hardware clear
   } bit_ctl_t;

endpackage

// File: rtl/regcell_decode.sv
module regcell_decode #(
   parameter int              ADDR_W   = 8,
   parameter int              DATA_W   = 32,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0,
   localparam int             LANES    = DATA_W / 8
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [LANES-1:0]  bus_bstrb,
   output logic [DATA_W-1:0] bit_wr,
   output logic              rd_hit
);

   logic sel;
   assign sel    = (bus_addr == REG_ADDR);
   assign rd_hit = sel & bus_rd_en;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign bit_wr[ln*8 +: 8] = {8{sel & bus_wr_en & bus_bstrb[ln]}};
   end

endmodule

// File: rtl/regcell_bit.sv
module regcell_bit
   import regcell_pkg::*;
#(
   parameter logic [MODE_W-1:0] MODE    = ACC_RW,
   parameter logic              RST_BIT = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  bit_ctl_t ctl,
   output logic     q,
   output logic     rd_bit,
   output logic     pulse
);

   logic sw_upd;
   logic sw_nxt;
   logic unused_ctl;

   assign unused_ctl = ^ctl;

   // software effect selected by the access mode
   if (MODE == ACC_RW || MODE == ACC_WO) begin : g_store
      assign sw_upd = ctl.wr;
      assign sw_nxt = ctl.wd;
   end else if (MODE == ACC_RO || MODE == ACC_TRIG) begin : g_hold
      assign sw_upd = 1'b0;
      assign sw_nxt = 1'b0;
   end else if (MODE == ACC_W1C) begin : g_w1c
      assign sw_upd = ctl.wr & ctl.wd;
      assign sw_nxt = 1'b0;
   end else if (MODE == ACC_W0C) begin : g_w0c
      assign sw_upd = ctl.wr & ~ctl.wd;
      assign sw_nxt = 1'b0;
   end else if (MODE == ACC_RCLR) begin : g_rclr
      assign sw_upd = ctl.rd;
      assign sw_nxt = 1'b0;
   end else if (MODE == ACC_W1S) begin : g_w1s
      assign sw_upd = ctl.wr & ctl.wd;
      assign sw_nxt = 1'b1;
   end else if (MODE == ACC_W1T) begin : g_w1t
      assign sw_upd = ctl.wr & ctl.wd;
      assign sw_nxt = ~q;
   end else begin : g_bad
      $error("regcell_bit: unknown access mode");
      assign sw_upd = 1'b0;
      assign sw_nxt = 1'b0;
   end

   // hardware set beats hardware clear beats software
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= RST_BIT;
      else if (ctl.hset) q <= 1'b1;
      else if (ctl.hclr) q <= 1'b0;
      else if (sw_upd)   q <= sw_nxt;
   end

   if (MODE == ACC_WO) begin : g_rd_rst
      assign rd_bit = RST_BIT;
   end else begin : g_rd_q
      assign rd_bit = q;
   end

   if (MODE == ACC_TRIG) begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse <= 1'b0;
         else        pulse <= ctl.wr;
      end
   end else begin : g_nopulse
      assign pulse = 1'b0;
   end

endmodule

// File: rtl/regcell_rdmux.sv
module regcell_rdmux #(
   parameter int DATA_W = 32
) (
   input  logic              rd_hit,
   input  logic [DATA_W-1:0] rd_bits,
   output logic [DATA_W-1:0] rdata
);

   assign rdata = rd_hit ? rd_bits : '0;

endmodule

// File: rtl/regcell_field.sv
module regcell_field
   import regcell_pkg::*;
#(
   parameter int                     DATA_W    = 32,
   parameter int                     ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]      REG_ADDR  = '0,
   parameter logic [DATA_W*MODE_W-1:0] MODE_VEC = '0,
   parameter logic [DATA_W-1:0]      RESET_VAL = '0,
   localparam int                    LANES     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [LANES-1:0]  bus_bstrb,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] hw_set,
   input  logic [DATA_W-1:0] hw_clr,
   output logic [DATA_W-1:0] hw_val,
   output logic [DATA_W-1:0] trig_pulse
);

   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_chk_w
      $error("regcell_field: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1) begin : g_chk_a
      $error("regcell_field: ADDR_W must be at least 1");
   end

   logic [DATA_W-1:0] bit_wr;
   logic              rd_hit;
   logic [DATA_W-1:0] rd_bits;

   regcell_decode #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .REG_ADDR(REG_ADDR)
   ) u_dec (
      .bus_addr (bus_addr),
      .bus_wr_en(bus_wr_en),
      .bus_rd_en(bus_rd_en),
      .bus_bstrb(bus_bstrb),
      .bit_wr   (bit_wr),
      .rd_hit   (rd_hit)
   );

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam logic [MODE_W-1:0] BMODE = MODE_VEC[b*MODE_W +: MODE_W];
      if (BMODE > ACC_LAST) begin : g_chk_m
         $error("regcell_field: mode code out of range");
      end
      bit_ctl_t ctl;
      assign ctl = '{wr: bit_wr[b], wd: bus_wdata[b], rd: rd_hit,
                     hset: hw_set[b], hclr: hw_clr[b]};
      regcell_bit #(
         .MODE   (BMODE),
         .RST_BIT(RESET_VAL[b])
      ) u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .ctl   (ctl),
         .q     (hw_val[b]),
         .rd_bit(rd_bits[b]),
         .pulse (trig_pulse[b])
      );
   end

   regcell_rdmux #(.DATA_W(DATA_W)) u_rd (
      .rd_hit (rd_hit),
      .rd_bits(rd_bits),
      .rdata  (bus_rdata)
   );

endmodule

// File: rtl/regcell_field_chk.sv
module regcell_field_chk
   import regcell_pkg::*;
#(
   parameter int                       DATA_W    = 32,
   parameter int                       ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]        REG_ADDR  = '0,
   parameter logic [DATA_W*MODE_W-1:0] MODE_VEC  = '0,
   parameter logic [DATA_W-1:0]        RESET_VAL = '0,
   localparam int                      LANES     = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr_en,
   input logic              bus_rd_en,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [LANES-1:0]  bus_bstrb,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] hw_set,
   input logic [DATA_W-1:0] hw_clr,
   input logic [DATA_W-1:0] hw_val,
   input logic [DATA_W-1:0] trig_pulse
);

   logic hit;
   assign hit = (bus_addr == REG_ADDR);

   // R12: idle read data is zero
   a_r12_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd_en && hit) |-> bus_rdata == '0);

   for (genvar b = 0; b < DATA_W; b++) begin : g_b
      localparam logic [MODE_W-1:0] M = MODE_VEC[b*MODE_W +: MODE_W];
      logic wl;
      logic quiet;
      assign wl    = bus_wr_en & hit & bus_bstrb[b/8];
      assign quiet = ~hw_set[b] & ~hw_clr[b];

      // R11: a hardware set is never lost
      a_r11_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         hw_set[b] |=> hw_val[b]);

      if (M == ACC_RO) begin : g_ro
         a_r3_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
            quiet |=> $stable(hw_val[b]));
      end
      if (M == ACC_WO) begin : g_wo
         a_r4_wo_read: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd_en && hit) |-> bus_rdata[b] == RESET_VAL[b]);
      end
      if (M == ACC_W1C) begin : g_w1c
         a_r5_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wl && bus_wdata[b] && quiet) |=> !hw_val[b]);
      end
      if (M == ACC_W0C) begin : g_w0c
         a_r6_w0c_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wl && !bus_wdata[b] && quiet) |=> !hw_val[b]);
      end
      if (M == ACC_RCLR) begin : g_rc
         a_r7_rc_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd_en && hit && quiet) |=> !hw_val[b]);
         a_r7_rc_no_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!(bus_rd_en && hit) && quiet) |=> $stable(hw_val[b]));
      end
      if (M == ACC_W1S) begin : g_w1s
         a_r8_w1s_set: assert property (@(posedge clk) disable iff (!rst_n)
            (wl && bus_wdata[b] && !hw_clr[b]) |=> hw_val[b]);
      end
      if (M == ACC_TRIG) begin : g_trig
         a_r9_pulse_on_write: assert property (@(posedge clk) disable iff (!rst_n)
            wl |=> trig_pulse[b]);
         a_r9_pulse_only_write: assert property (@(posedge clk) disable iff (!rst_n)
            !wl |=> !trig_pulse[b]);
         a_r9_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
            quiet |=> $stable(hw_val[b]));
      end else begin : g_notrig
         a_r9_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_pulse[b]);
      end
      if (M == ACC_W1T) begin : g_w1t
         a_r10_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            (wl && bus_wdata[b] && quiet) |=> hw_val[b] != $past(hw_val[b]));
      end
   end

endmodule

bind regcell_field regcell_field_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .REG_ADDR (REG_ADDR),
   .MODE_VEC (MODE_VEC),
   .RESET_VAL(RESET_VAL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr_en (bus_wr_en),
   .bus_rd_en (bus_rd_en),
   .bus_wdata (bus_wdata),
   .bus_bstrb (bus_bstrb),
   .bus_rdata (bus_rdata),
   .hw_set    (hw_set),
   .hw_clr    (hw_clr),
   .hw_val    (hw_val),
   .trig_pulse(trig_pulse)
);

// File: tb/regcell_field_test.sv
`timescale 1ns/1ps
module regcell_field_test;

   localparam int          DW   = 16;
   localparam int          AW   = 4;
   localparam logic [3:0]  RADR = 4'h6;
   localparam logic [63:0] MV   = 64'h0000_5308_7654_3210;
   localparam logic [15:0] RV   = 16'h1014;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = RADR;
   logic          bus_wr_en = 1'b0;
   logic          bus_rd_en = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [1:0]    bus_bstrb = '0;
   logic [DW-1:0] bus_rdata;
   logic [DW-1:0] hw_set = '0;
   logic [DW-1:0] hw_clr = '0;
   logic [DW-1:0] hw_val;
   logic [DW-1:0] trig_pulse;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   regcell_field #(
      .DATA_W(DW), .ADDR_W(AW), .REG_ADDR(RADR),
      .MODE_VEC(MV), .RESET_VAL(RV)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
      .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
      .bus_wdata(bus_wdata), .bus_bstrb(bus_bstrb),
      .bus_rdata(bus_rdata), .hw_set(hw_set), .hw_clr(hw_clr),
      .hw_val(hw_val), .trig_pulse(trig_pulse)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bus_wr_en = 1'b0; bus_rd_en = 1'b0; hw_set = '0; hw_clr = '0;
      bus_addr = RADR;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [15:0] d, input logic [1:0] s);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_bstrb = s; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0; bus_bstrb = '0; bus_addr = RADR;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd_en = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd_en = 1'b0; bus_addr = RADR;
   endtask

   task automatic hw_pulse(input logic [15:0] s, input logic [15:0] c);
      @(negedge clk);
      hw_set = s; hw_clr = c;
      @(negedge clk);
      hw_set = '0; hw_clr = '0;
   endtask

   task automatic t_reset();
      logic [15:0] rd;
      do_reset();
      check("R1 reset value", hw_val, RV);
      check("R1 no pulse", trig_pulse, 0);
      check("R12 idle rdata", bus_rdata, 0);
      bus_read(RADR, rd);
      check("R1 read after reset", rd, RV);
   endtask

   task automatic t_rw();
      do_reset();
      bus_write(RADR, 16'hA5A5, 2'b10);
      check("R2 upper rw bits", hw_val[15:12], 4'hA);
      check("R2 bit9 written 0", hw_val[9], 0);
      check("R2 lower lane untouched", hw_val[7:0], 8'h14);
      bus_write(RADR, 16'h0000, 2'b00);
      check("R2 no strobe no change", hw_val[15:12], 4'hA);
      bus_write(RADR, 16'h0001, 2'b01);
      check("R2 bit0 written 1", hw_val[0], 1);
   endtask

   task automatic t_ro();
      do_reset();
      bus_write(RADR, 16'hFFFF, 2'b11);
      check("R3 ro ignores write 1", hw_val[1], 0);
      hw_pulse(16'h0002, 0);
      check("R3 ro hw set", hw_val[1], 1);
      bus_write(RADR, 16'h0000, 2'b11);
      check("R3 ro ignores write 0", hw_val[1], 1);
      hw_pulse(0, 16'h0002);
      check("R3 ro hw clear", hw_val[1], 0);
   endtask

   task automatic t_wo();
      logic [15:0] rd;
      do_reset();
      bus_write(RADR, 16'h0000, 2'b01);
      check("R4 wo stores 0", hw_val[2], 0);
      bus_read(RADR, rd);
      check("R4 wo reads reset value", rd[2], 1);
      bus_write(RADR, 16'h0004, 2'b01);
      check("R4 wo stores 1", hw_val[2], 1);
   endtask

   task automatic t_w1c();
      do_reset();
      hw_pulse(16'h0008, 0);
      check("R5 w1c set by hw", hw_val[3], 1);
      bus_write(RADR, 16'h0000, 2'b01);
      check("R5 w1c write 0 kept", hw_val[3], 1);
      bus_write(RADR, 16'h0008, 2'b01);
      check("R5 w1c write 1 clears", hw_val[3], 0);
   endtask

   task automatic t_w0c();
      do_reset();
      bus_write(RADR, 16'h0010, 2'b01);
      check("R6 w0c write 1 kept", hw_val[4], 1);
      bus_write(RADR, 16'h0000, 2'b01);
      check("R6 w0c write 0 clears", hw_val[4], 0);
   endtask

   task automatic t_rc();
      logic [15:0] rd;
      do_reset();
      hw_pulse(16'h0020, 0);
      bus_write(RADR, 16'h0000, 2'b11);
      check("R7 rc ignores write", hw_val[5], 1);
      repeat (2) @(negedge clk);
      check("R7 no read no clear", hw_val[5], 1);
      bus_read(4'h5, rd);
      check("R7 other address no clear", hw_val[5], 1);
      bus_read(RADR, rd);
      check("R7 rc returns value", rd[5], 1);
      check("R7 rc cleared after read", hw_val[5], 0);
      bus_read(RADR, rd);
      check("R7 rc second read 0", rd[5], 0);
   endtask

   task automatic t_w1s();
      do_reset();
      bus_write(RADR, 16'h0000, 2'b01);
      check("R8 w1s write 0 stays 0", hw_val[6], 0);
      bus_write(RADR, 16'h0040, 2'b01);
      check("R8 w1s write 1 sets", hw_val[6], 1);
      bus_write(RADR, 16'h0000, 2'b01);
      check("R8 w1s write 0 keeps 1", hw_val[6], 1);
   endtask

   task automatic t_trig();
      do_reset();
      bus_write(RADR, 16'h0080, 2'b01);
      check("R9 pulse after write 1", trig_pulse[7], 1);
      check("R9 value unchanged", hw_val[7], 0);
      @(negedge clk);
      check("R9 pulse one cycle", trig_pulse[7], 0);
      bus_write(RADR, 16'h0000, 2'b01);
      check("R9 pulse after write 0", trig_pulse[7], 1);
      bus_write(RADR, 16'h0080, 2'b10);
      check("R9 no pulse unstrobed", trig_pulse[7], 0);
   endtask

   task automatic t_tog();
      do_reset();
      bus_write(RADR, 16'h0100, 2'b10);
      check("R10 toggle to 1", hw_val[8], 1);
      bus_write(RADR, 16'h0000, 2'b10);
      check("R10 write 0 no effect", hw_val[8], 1);
      bus_write(RADR, 16'h0100, 2'b10);
      check("R10 toggle to 0", hw_val[8], 0);
   endtask

   task automatic t_race();
      logic [15:0] rd;
      do_reset();
      @(negedge clk);
      bus_wdata = 16'h0008; bus_bstrb = 2'b01; bus_wr_en = 1'b1; hw_set = 16'h0008;
      @(negedge clk);
      bus_wr_en = 1'b0; bus_bstrb = '0; hw_set = '0;
      check("R11 hw set beats w1c", hw_val[3], 1);
      @(negedge clk);
      bus_rd_en = 1'b1; hw_set = 16'h0020;
      #1 rd = bus_rdata;
      @(negedge clk);
      bus_rd_en = 1'b0; hw_set = '0;
      check("R11 read during set returns old", rd[5], 0);
      check("R11 rc set during read stays", hw_val[5], 1);
      hw_pulse(16'h0001, 16'h0001);
      check("R11 set beats hw clear", hw_val[0], 1);
   endtask

   task automatic t_addr();
      logic [15:0] rd;
      do_reset();
      bus_write(4'h5, 16'hFFFF, 2'b11);
      check("R12 write other address ignored", hw_val, RV);
      bus_read(4'h5, rd);
      check("R12 read other address zero", rd, 0);
      @(negedge clk);
      bus_addr = RADR; bus_rd_en = 1'b0;
      #1 check("R12 no rd_en zero", bus_rdata, 0);
   endtask

   initial begin
      #100000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_rw();
      t_ro();
      t_wo();
      t_w1c();
      t_w0c();
      t_rc();
      t_w1s();
      t_trig();
      t_tog();
      t_race();
      t_addr();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule